// File: doc/BRIEF.md
# Line-Quadrupled Framebuffer Scanout for 640x480 VGA

This block produces standard 640x480, 60 Hz VGA timing from a 25.175 MHz pixel clock. It also streams a packed framebuffer of 216 x 120 pixels, four bits per pixel, to a 4-bit colour index output. A horizontal line lasts 800 clocks and a frame lasts 525 lines. Every framebuffer pixel is stretched to three clocks wide. Every framebuffer row is repeated on four consecutive display lines, so the image fills 648 clocks by 480 lines.

Framebuffer bytes come through a synchronous read port: the block raises `fetch_req` with `fetch_addr` in one cycle and expects the byte on `fetch_byte` in the next. A row holds 108 bytes. On the three lines that repeat a row, the block moves the read address back by one row. At the frame wrap it reloads the base address. The `bus_claim` output tells the surrounding arbiter when the block needs the shared memory bus. The DAC, palette and memory sit outside the block.

Top module: `fb_scanout`

## Requirements
- R1: A line lasts H_SYNC+H_BACK+H_ACTIVE+H_FRONT clocks (default 800). `hsync_n` is low for the first H_SYNC clocks (default 96) of every line and high for the rest of the line.
- R2: A frame lasts V_ACTIVE+V_FRONT+V_SYNC+V_BACK lines (default 525), and the line count wraps from the last line to 0. `vsync_n` is low on lines V_ACTIVE+V_FRONT through V_ACTIVE+V_FRONT+V_SYNC-1 (default lines 492 and 493) and high on all other lines.
- R3: `blank` is low only on lines 0 to V_ACTIVE-1 (default 479), during a window of ROW_BYTES*2*PIX_CLKS clocks (default 648). The window starts PIX_OFFSET clocks after `hsync_n` rises (default 40). While `blank` is high, `colour` is 0.
- R4: Byte k of a row is shown during window clocks 2*PIX_CLKS*k through 2*PIX_CLKS*k+2*PIX_CLKS-1. The byte's bits [3:0] are shown for the first PIX_CLKS clocks and bits [7:4] for the next PIX_CLKS clocks.
- R5: On a visible line, `fetch_req` is a one-cycle pulse. It is raised exactly 2 clocks before the first display clock of each byte, and the byte is taken from `fetch_byte` in the following cycle.
- R6: On visible line L, the block requests the addresses FB_BASE + (L / LINE_REPEAT) * ROW_BYTES + k for k = 0 to ROW_BYTES-1, in increasing order. The address therefore advances by one row only on lines where L mod LINE_REPEAT is 0, and the same row is requested again on the other lines.
- R7: Line 0 of every frame, including every frame after the first, requests its bytes starting at FB_BASE.
- R8: `fetch_req` stays low on every line from V_ACTIVE (default 480) through the last line of the frame.
- R9: `bus_claim` is high during the sync part of every line. On visible lines it stays high until the front porch begins, at clock H_SYNC+H_BACK+H_ACTIVE. In every other cycle it is low. Every read falls inside a claimed cycle.
- R10: While `rst_n` is low, the outputs are: `hsync_n` 0, `vsync_n` 1, `blank` 1, `colour` 0, `fetch_req` 0, `bus_claim` 1. After release, timing restarts at clock 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | High outside the visible pixel window |
| colour | output | 4 | Colour index of the current pixel |
| fetch_req | output | 1 | Framebuffer read strobe |
| fetch_addr | output | ADDR_W | Framebuffer byte address |
| fetch_byte | input | 8 | Read data, valid the cycle after `fetch_req` |
| bus_claim | output | 1 | High while the scanout owns the shared memory bus |

## Verification
The bench builds the block with reduced timing: a 58-clock line (sync 8, back porch 6, active 40, front porch 4) and a 19-line frame (12 visible, 2 front porch, 2 sync, 3 back porch). It also uses 6-byte rows, a 4-clock pixel offset, 8-bit addresses and a base of 100. With these values a frame takes 1102 clocks. Several frame wraps, all three repeats of each row, the vsync lines and a reset in the middle of a frame all fit in a short run. Every output is compared each cycle against a behavioural model of the timing and addressing. Framebuffer contents are rewritten during a blanked interval, which shows that pixels come from fresh reads and not from stale data.

// File: rtl/fb_scanout.sv
module fb_scanout #(
  parameter int H_SYNC      = 96,
  parameter int H_BACK      = 48,
  parameter int H_ACTIVE    = 640,
  parameter int H_FRONT     = 16,
  parameter int V_ACTIVE    = 480,
  parameter int V_FRONT     = 12,
  parameter int V_SYNC      = 2,
  parameter int V_BACK      = 31,
  parameter int ROW_BYTES   = 108,
  parameter int PIX_CLKS    = 3,
  parameter int LINE_REPEAT = 4,
  parameter int PIX_OFFSET  = 40,
  parameter int ADDR_W      = 16,
  parameter int FB_BASE     = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              blank,
  output logic [3:0]        colour,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic [7:0]        fetch_byte,
  output logic              bus_claim
);

  localparam int H_TOTAL   = H_SYNC + H_BACK + H_ACTIVE + H_FRONT;
  localparam int V_TOTAL   = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HC_W      = $clog2(H_TOTAL + 1);
  localparam int VC_W      = $clog2(V_TOTAL + 1);
  localparam int BYTE_CLKS = 2 * PIX_CLKS;
  localparam int ROW_CLKS  = ROW_BYTES * BYTE_CLKS;
  localparam int WIN_START = H_SYNC + PIX_OFFSET;
  localparam int FP_START  = H_SYNC + H_BACK + H_ACTIVE;
  localparam int REP_W     = $clog2(LINE_REPEAT + 1);
  localparam int FPH_W     = $clog2(BYTE_CLKS + 1);
  localparam int PC_W      = $clog2(PIX_CLKS + 1);

  localparam logic [HC_W-1:0]   HC_LAST   = HC_W'(H_TOTAL - 1);
  localparam logic [HC_W-1:0]   HS_END    = HC_W'(H_SYNC);
  localparam logic [HC_W-1:0]   WIN_LO    = HC_W'(WIN_START);
  localparam logic [HC_W-1:0]   WIN_HI    = HC_W'(WIN_START + ROW_CLKS);
  localparam logic [HC_W-1:0]   FETCH_LO  = HC_W'(WIN_START - 2);
  localparam logic [HC_W-1:0]   FETCH_HI  = HC_W'(WIN_START - 2 + ROW_CLKS);
  localparam logic [HC_W-1:0]   FP_LO     = HC_W'(FP_START);
  localparam logic [VC_W-1:0]   VC_LAST   = VC_W'(V_TOTAL - 1);
  localparam logic [VC_W-1:0]   VC_ACT    = VC_W'(V_ACTIVE);
  localparam logic [VC_W-1:0]   VC_ACT_M1 = VC_W'(V_ACTIVE - 1);
  localparam logic [VC_W-1:0]   VS_LO     = VC_W'(V_ACTIVE + V_FRONT);
  localparam logic [VC_W-1:0]   VS_HI     = VC_W'(V_ACTIVE + V_FRONT + V_SYNC);
  localparam logic [REP_W-1:0]  REP_LAST  = REP_W'(LINE_REPEAT - 1);
  localparam logic [FPH_W-1:0]  FPH_LAST  = FPH_W'(BYTE_CLKS - 1);
  localparam logic [PC_W-1:0]   PC_LAST   = PC_W'(PIX_CLKS - 1);
  localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(FB_BASE);
  localparam logic [ADDR_W-1:0] ROW_STEP  = ADDR_W'(ROW_BYTES);

  logic [HC_W-1:0]   hc;
  logic [VC_W-1:0]   vc;
  logic [REP_W-1:0]  rep;
  logic [ADDR_W-1:0] ptr;
  logic [FPH_W-1:0]  fph;
  logic [PC_W-1:0]   pcnt;
  logic              nib_hi;
  logic              byte_due;
  logic [7:0]        pix;

  logic line_end, frame_end, line_vis, in_fetch, in_win;

  assign line_end  = (hc == HC_LAST);
  assign frame_end = (vc == VC_LAST);
  assign line_vis  = (vc < VC_ACT);
  assign in_fetch  = (hc >= FETCH_LO) && (hc < FETCH_HI);
  assign in_win    = (hc >= WIN_LO) && (hc < WIN_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc  <= '0;
      vc  <= '0;
      rep <= '0;
      ptr <= BASE_ADDR;
    end else if (line_end) begin
      hc  <= '0;
      vc  <= frame_end ? '0 : vc + 1'b1;
      rep <= (frame_end || rep == REP_LAST) ? '0 : rep + 1'b1;
      if (frame_end)
        ptr <= BASE_ADDR;
      else if (vc < VC_ACT_M1 && rep != REP_LAST)
        ptr <= ptr - ROW_STEP;
    end else begin
      hc <= hc + 1'b1;
      if (fetch_req) ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             fph <= '0;
    else if (!in_fetch)     fph <= '0;
    else if (fph == FPH_LAST) fph <= '0;
    else                    fph <= fph + 1'b1;
  end

  assign fetch_req  = line_vis && in_fetch && (fph == '0);
  assign fetch_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_due <= 1'b0;
      pix      <= '0;
    end else begin
      byte_due <= fetch_req;
      if (byte_due) pix <= fetch_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt   <= '0;
      nib_hi <= 1'b0;
    end else if (!in_win) begin
      pcnt   <= '0;
      nib_hi <= 1'b0;
    end else if (pcnt == PC_LAST) begin
      pcnt   <= '0;
      nib_hi <= ~nib_hi;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  assign hsync_n   = (hc >= HS_END);
  assign vsync_n   = !((vc >= VS_LO) && (vc < VS_HI));
  assign blank     = !(line_vis && in_win);
  assign colour    = blank ? 4'd0 : (nib_hi ? pix[7:4] : pix[3:0]);
  assign bus_claim = (hc < HS_END) || (line_vis && hc < FP_LO);

endmodule

// File: rtl/fb_scanout_chk.sv
module fb_scanout_chk #(
  parameter int H_SYNC  = 96,
  parameter int H_TOTAL = 800
) (
  input logic       clk,
  input logic       rst_n,
  input logic       hsync_n,
  input logic       vsync_n,
  input logic       blank,
  input logic [3:0] colour,
  input logic       fetch_req,
  input logic       bus_claim
);

  logic        hs_q;
  logic [31:0] since_line;
  logic        line_start;

  assign line_start = hs_q && !hsync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q       <= 1'b0;
      since_line <= '0;
    end else begin
      hs_q       <= hsync_n;
      since_line <= line_start ? 32'd1 : since_line + 32'd1;
    end
  end

  // R1: a new line begins exactly one line period after the previous one
  p_line_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> since_line == 32'(H_TOTAL));

  // R1: sync pulse width
  p_sync_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_n) |-> since_line == 32'(H_SYNC));

  // R2: vertical sync only changes at a line start
  p_vs_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(vsync_n) || $rose(vsync_n)) |-> line_start);

  // R3: no visible pixel during vertical sync, and dark while blanked
  p_vs_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> (blank && colour == 4'd0));

  // R5: read strobe is a single-cycle pulse
  p_single_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> !fetch_req);

  // R8: no reads during vertical sync
  p_no_read_vs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> !fetch_req);

  // R9: every read happens while the bus is claimed
  p_read_owned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> bus_claim);

endmodule

bind fb_scanout fb_scanout_chk #(
  .H_SYNC (H_SYNC),
  .H_TOTAL(H_SYNC + H_BACK + H_ACTIVE + H_FRONT)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .hsync_n  (hsync_n),
  .vsync_n  (vsync_n),
  .blank    (blank),
  .colour   (colour),
  .fetch_req(fetch_req),
  .bus_claim(bus_claim)
);

// File: tb/fb_scanout_tb_top.sv
module fb_scanout_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HS = 8, HB = 6, HA = 40, HF = 4;
  localparam int VA = 12, VF = 2, VS = 2, VB = 3;
  localparam int RB = 6, PC = 3, LR = 4, OFS = 4, AW = 8, BASE = 100;
  localparam int HT = HS + HB + HA + HF;
  localparam int VT = VA + VF + VS + VB;
  localparam int WS = HS + OFS;
  localparam int RC = RB * 2 * PC;
  localparam int FP = HS + HB + HA;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hsync_n, vsync_n, blank, fetch_req, bus_claim;
  logic [3:0]    colour;
  logic [AW-1:0] fetch_addr;
  logic [7:0]    fetch_byte = 8'd0;
  logic [7:0]    mem [0:255];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fb_scanout #(
    .H_SYNC(HS), .H_BACK(HB), .H_ACTIVE(HA), .H_FRONT(HF),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .ROW_BYTES(RB), .PIX_CLKS(PC), .LINE_REPEAT(LR), .PIX_OFFSET(OFS),
    .ADDR_W(AW), .FB_BASE(BASE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .blank(blank), .colour(colour), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_byte(fetch_byte), .bus_claim(bus_claim)
  );

  always @(posedge clk) if (fetch_req) fetch_byte <= mem[fetch_addr];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic fill(input int mul, input int add);
    for (int a = 0; a < 256; a++) mem[a] = 8'((a * mul + add) & 8'hff);
  endtask

  task automatic check_reset();
    check(hsync_n == 1'b0,   "R10 hsync_n", int'(hsync_n), 0);
    check(vsync_n == 1'b1,   "R10 vsync_n", int'(vsync_n), 1);
    check(blank == 1'b1,     "R10 blank", int'(blank), 1);
    check(colour == 4'd0,    "R10 colour", int'(colour), 0);
    check(fetch_req == 1'b0, "R10 fetch_req", int'(fetch_req), 0);
    check(bus_claim == 1'b1, "R10 bus_claim", int'(bus_claim), 1);
  endtask

  task automatic compare(input int h, input int v, input int frame);
    bit vis, win, rd;
    int e_hs, e_vs, e_bl, e_col, e_own, p, a, fa;
    vis  = (v < VA);
    win  = (h >= WS) && (h < WS + RC);
    e_hs = (h < HS) ? 0 : 1;
    e_vs = (v >= VA + VF && v < VA + VF + VS) ? 0 : 1;
    e_bl = (vis && win) ? 0 : 1;
    e_col = 0;
    if (e_bl == 0) begin
      p = h - WS;
      a = BASE + (v / LR) * RB + p / (2 * PC);
      e_col = ((p / PC) % 2 == 1) ? int'(mem[a][7:4]) : int'(mem[a][3:0]);
    end
    e_own = (h < HS || (vis && h < FP)) ? 1 : 0;
    rd = vis && (h >= WS - 2) && (h < WS - 2 + RC) && ((h - WS + 2) % (2 * PC) == 0);
    check(int'(hsync_n) == e_hs, "R1 hsync_n", int'(hsync_n), e_hs);
    check(int'(vsync_n) == e_vs, "R2 vsync_n", int'(vsync_n), e_vs);
    check(int'(blank) == e_bl, "R3 blank", int'(blank), e_bl);
    check(int'(colour) == e_col, "R4 colour", int'(colour), e_col);
    check(int'(bus_claim) == e_own, "R9 bus_claim", int'(bus_claim), e_own);
    if (vis) check(fetch_req == rd, "R5 fetch_req", int'(fetch_req), int'(rd));
    else     check(fetch_req == 1'b0, "R8 fetch_req", int'(fetch_req), 0);
    if (rd && fetch_req) begin
      fa = BASE + (v / LR) * RB + (h - WS + 2) / (2 * PC);
      if (v == 0 && frame > 0)
        check(int'(fetch_addr) == fa, "R7 fetch_addr", int'(fetch_addr), fa);
      else
        check(int'(fetch_addr) == fa, "R6 fetch_addr", int'(fetch_addr), fa);
    end
  endtask

  initial begin
    int h, v, frame;
    fill(37, 11);
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    h = 0; v = 0; frame = 0;
    for (int n = 0; n < 4200; n++) begin
      if (n == 2700) begin
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        h = 0; v = 0;
      end
      if (frame == 0 && v == VA + 1 && h == 0) fill(91, 5);
      compare(h, v, frame);
      h++;
      if (h == HT) begin
        h = 0; v++;
        if (v == VT) begin v = 0; frame++; end
      end
      @(negedge clk);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule